// File: doc/BRIEF.md
# Write-once prescaled tick divider

This block holds an 8-bit control register that sets the rate of a slow timing tick for nonvolatile-memory program and erase sequencing. Software writes the register once after reset: the low six bits give a divide field, the next bit switches in a fixed divide-by-8 stage ahead of the programmable divider, and the top bit is a flag that hardware sets on that first write. Every later write is ignored, so the tick rate cannot be disturbed once sequencing has started.

The tick is a one-cycle enable in the system clock domain. It stays low until the register has been loaded. After that it fires once every (prescale ? 8 : 1) × (field + 1) cycles, a ratio from 1 to 512. The accepted write clears both counters, so the first tick arrives one full period after it. The bus port is a plain write strobe with data and a combinational read-back. The `ready` pin mirrors the loaded flag.

Top module: `nvm_tick_div`

## Requirements
- R1: After reset, `rd_data` reads 0x00 and `ready` is 0.
- R2: The first write after reset stores `wr_data[6:0]` into bits 6:0. From the next cycle these read back as written.
- R3: Bit 7 (loaded flag) ignores the written value. It reads 1 from the cycle after the first write even when that write carries 0 in bit 7, and it stays 1 until reset.
- R4: A write after the loaded flag is set changes neither `rd_data` nor the phase of the tick sequence.
- R5: `tick` stays 0 while the loaded flag is 0.
- R6: When loaded, `tick` has a period of P = (bit6 ? 8 : 1) × (bits5:0 + 1) cycles. Bit 6 set selects the divide-by-8 stage.
- R7: The first `tick` is high in the P-th cycle after the cycle of the accepted write.
- R8: When P > 1, each `tick` pulse lasts exactly one cycle.
- R9: `ready` equals bit 7 of `rd_data` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Register read-back {loaded, prescale, field} |
| tick | output | 1 | One-cycle divided timing enable |
| ready | output | 1 | Loaded flag, tick running |

## Verification
The hardest condition to reach is a second write that lands while the divider is partway through a period. If that write were wrongly accepted, it would restart the counters and the error would show only as a shifted tick. The bench therefore issues a write with inverted data on the exact cycle a tick is observed. It then measures the distance to the next tick, across all 128 prescale and field combinations, each starting from a fresh reset. Each first write also carries bit 7 at a value that varies with the field, so that the flag is seen to ignore the data.

// File: rtl/nvm_div_pkg.sv
package nvm_div_pkg;
  localparam int unsigned DIV_W    = 6;
  localparam int unsigned PRE_LOG2 = 3;
  localparam int unsigned REG_W    = DIV_W + 2;

  typedef struct packed {
    logic             pre_en;
    logic [DIV_W-1:0] div;
  } div_cfg_t;

  function automatic int unsigned period_of(input div_cfg_t c);
    return (c.pre_en ? (1 << PRE_LOG2) : 1) * (int'(c.div) + 1);
  endfunction
endpackage

// File: rtl/nvm_div_cfg_reg.sv
module nvm_div_cfg_reg
  import nvm_div_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output div_cfg_t         cfg,
  output logic             loaded,
  output logic             restart
);
  // only the first write after reset is taken
  assign restart = wr_en & ~loaded;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg    <= '0;
      loaded <= 1'b0;
    end else if (restart) begin
      cfg    <= wr_data[DIV_W:0];
      loaded <= 1'b1;
    end
  end
endmodule

// File: rtl/nvm_div_prescale.sv
module nvm_div_prescale #(
  parameter int unsigned LOG2 = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  input  logic bypass,
  output logic stb
);
  generate
    if (LOG2 == 0) begin : g_none
      assign stb = run;
    end else begin : g_cnt
      logic [LOG2-1:0] cnt;
      always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (run)      cnt <= cnt + 1'b1;
      end
      assign stb = run & (bypass | (&cnt));
    end
  endgenerate
endmodule

// File: rtl/nvm_div_counter.sv
module nvm_div_counter #(
  parameter int unsigned W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  input  logic [W-1:0] limit,
  output logic         hit
);
  logic [W-1:0] cnt;

  assign hit = step & (cnt == limit);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt <= '0;
    else if (step)     cnt <= hit ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/nvm_tick_div.sv
module nvm_tick_div
  import nvm_div_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             tick,
  output logic             ready
);
  div_cfg_t cfg;
  logic     loaded, restart, pre_stb, hit;

  nvm_div_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .cfg(cfg), .loaded(loaded), .restart(restart)
  );

  nvm_div_prescale #(.LOG2(PRE_LOG2)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(restart), .run(loaded),
    .bypass(~cfg.pre_en), .stb(pre_stb)
  );

  nvm_div_counter #(.W(DIV_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .clr(restart), .step(pre_stb),
    .limit(cfg.div), .hit(hit)
  );

  assign tick    = loaded & hit;
  assign ready   = loaded;
  assign rd_data = {loaded, cfg};
endmodule

// File: rtl/nvm_tick_div_chk.sv
module nvm_tick_div_chk
  import nvm_div_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_data,
  input logic [REG_W-1:0] rd_data,
  input logic             tick,
  input logic             ready
);
  AST_TICK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !tick); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready); // R3
  AST_FIRST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && wr_en) |=> (ready && rd_data[REG_W-2:0] == $past(wr_data[REG_W-2:0]))); // R2
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> $stable(rd_data)); // R4
  AST_TICK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && rd_data[REG_W-2:0] != '0) |=> !tick); // R8
  AST_READY_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    ready == rd_data[REG_W-1]); // R9
endmodule

bind nvm_tick_div nvm_tick_div_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .tick(tick), .ready(ready)
);

// File: tb/nvm_tick_div_tb.sv
module nvm_tick_div_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       tick, ready;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  nvm_tick_div u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .tick(tick), .ready(ready)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // counts cycles to next tick; optionally writes junk on the first cycle
  task automatic measure(input int per, input bit poke, input logic [7:0] junk,
                         output int cyc);
    int c = 0;
    bit wide = 0;
    if (poke) begin wr_en = 1'b1; wr_data = junk; end
    do begin
      @(negedge clk);
      wr_en = 1'b0;
      c++;
      if (c == 1 && per > 1 && tick) wide = 1;
    end while (!tick && c < 600);
    chk(!wide, "R8 pulse width", int'(wide), 0);
    cyc = c;
  endtask

  initial begin
    for (int pre = 0; pre < 2; pre++) begin
      for (int div = 0; div < 64; div++) begin
        int per, c;
        bit early;
        logic [7:0] val, expect_rd;
        per = (pre ? 8 : 1) * (div + 1);
        val = {div[0], pre[0], div[5:0]};
        expect_rd = {1'b1, pre[0], div[5:0]};
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rd_data == 8'h00 && !ready, "R1 reset state", int'(rd_data), 0);
        early = 0;
        for (int i = 0; i < 10; i++) begin
          @(negedge clk);
          if (tick) early = 1;
        end
        chk(!early, "R5 tick before load", int'(early), 0);
        // first write
        wr_en = 1'b1; wr_data = val;
        @(negedge clk);
        wr_en = 1'b0;
        chk(rd_data == expect_rd, "R2 R3 first write readback", int'(rd_data), int'(expect_rd));
        chk(ready == rd_data[7], "R9 ready mirror", int'(ready), int'(rd_data[7]));
        c = 1;
        while (!tick && c < 600) begin @(negedge clk); c++; end
        chk(c == per, "R7 first tick delay", c, per);
        measure(per, 1'b1, ~val, c);
        chk(c == per, "R4 R6 period with late write", c, per);
        chk(rd_data == expect_rd, "R4 readback unchanged", int'(rd_data), int'(expect_rd));
        measure(per, 1'b0, 8'h00, c);
        chk(c == per, "R6 period", c, per);
      end
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 190000; i++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule